// File: doc/BRIEF.md
# RISC-V Alias Recognition Unit

This block inspects one 32-bit base-ISA instruction word at a time and decides whether the word is a form that an assembler would print under a shorter alias name, for example a no-op, a register move, a compare-against-zero branch, a return, or a write-only CSR access. The answer is a small numeric alias code plus a flag that is high whenever any alias applies. A disassembler, trace formatter or debug unit places it beside its own decode and uses the code to choose the printed mnemonic.

The word is accepted on a cycle where `in_valid` is high, and the result appears on the registered outputs on the next clock edge. Between accepted words the outputs keep their last value. If several aliases fit one word, a fixed priority picks one of them. A word that fits no alias, including any opcode outside the covered groups, yields code NONE with the flag low. The `XLEN` parameter selects a 32-bit or a 64-bit base. The 32-bit-operation opcode group is recognised only when `XLEN` is 64.

Top module: `alias_classifier`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `in_valid` high, and is low otherwise.
- R2: After synchronous reset `res_valid`=0, `res_hit`=0 and `res_code`=0. While `in_valid` is low, `res_code` and `res_hit` keep their values no matter what `in_word` carries.
- R3: Instruction fields are taken from these bit positions: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25], imm [31:20]. `res_hit` is 1 exactly when `res_code` is non-zero. A word that matches no alias, including any uncovered opcode, gives code 0 (NONE).
- R4: Opcode 0010011 with funct3 000: if rd, rs1 and imm are all zero the code is 1 (nop). This takes priority. Otherwise, if imm is zero, the code is 2 (mv).
- R5: Opcode 0010011 with funct3 111 and imm 0x0FF gives 3 (zext.b). With funct3 100 and imm 0xFFF it gives 4 (not). With funct3 011 and imm 0x001 it gives 5 (seqz).
- R6: Opcode 0110011 with funct7 0100000, funct3 000 and rs1=0 gives 7 (neg). With funct7 0000000, funct3 011 and rs1=0 it gives 6 (snez). Opcode 0111011 with funct7 0100000, funct3 000 and rs1=0 gives 8 (negw) when XLEN=64 and 0 when XLEN=32.
- R7: Opcode 1100011: funct3 000 with rs2=0 gives 9 (beqz), and funct3 001 with rs2=0 gives 10 (bnez). For funct3 100, rs2=0 gives 11 (bltz) with priority, and otherwise rs1=0 gives 12 (bgtz). For funct3 101, rs1=0 gives 13 (blez) with priority, and otherwise rs2=0 gives 14 (bgez).
- R8: Opcode 1101111 with rd=0 gives 15 (j), and with rd=1 gives 16 (short jal). Opcode 1100111 with funct3 000 and rd=0 gives 18 (ret) when rs1=1 and imm=0, which takes priority, and otherwise gives 17 (jr).
- R9: Opcode 0001111 with funct3 000: predecessor set [27:24]=0001, successor set [23:20]=0000, rd=0 and rs1=0 gives 19 (pause) with priority. Otherwise predecessor and successor both 1111 gives 20 (full fence).
- R10: Opcode 1110011 by funct3: 010 with rs1=0 gives 21 (csrr) with priority. With rd=0, funct3 001/010/011/101/110/111 give 22/23/24/25/26/27 (csrw, csrs, csrc, csrwi, csrsi, csrci).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_word | input | 32 | Instruction word to classify |
| res_valid | output | 1 | Result updated on this cycle's outputs |
| res_hit | output | 1 | Some alias matched |
| res_code | output | 5 | Alias code, 0 when none matched |

## Verification
On every cycle the assertions check the one-cycle result timing, that the outputs hold while no word is presented, and that the flag agrees with the code. They also check a few fixed encodings (the canonical no-op and return) and that a branch word only ever yields a branch alias or NONE. The priority between overlapping aliases, the exact immediate values, the fence sets, the CSR write-only forms and the effect of the XLEN choice are shown only by the bench. It combines directed words with random words that are biased toward zero registers and special immediates, and checks each result against its own reference function.

// File: rtl/alias_pkg.sv
package alias_pkg;

  localparam int ILEN   = 32;
  localparam int CODE_W = 5;

  typedef enum logic [CODE_W-1:0] {
    A_NONE  = 5'd0,  A_NOP   = 5'd1,  A_MV    = 5'd2,  A_ZEXTB = 5'd3,
    A_NOT   = 5'd4,  A_SEQZ  = 5'd5,  A_SNEZ  = 5'd6,  A_NEG   = 5'd7,
    A_NEGW  = 5'd8,  A_BEQZ  = 5'd9,  A_BNEZ  = 5'd10, A_BLTZ  = 5'd11,
    A_BGTZ  = 5'd12, A_BLEZ  = 5'd13, A_BGEZ  = 5'd14, A_J     = 5'd15,
    A_JALRA = 5'd16, A_JR    = 5'd17, A_RET   = 5'd18, A_PAUSE = 5'd19,
    A_FENCE = 5'd20, A_CSRR  = 5'd21, A_CSRW  = 5'd22, A_CSRS  = 5'd23,
    A_CSRC  = 5'd24, A_CSRWI = 5'd25, A_CSRSI = 5'd26, A_CSRCI = 5'd27
  } alias_e;

  localparam logic [6:0] OPC_ALUI  = 7'b0010011;
  localparam logic [6:0] OPC_ALUR  = 7'b0110011;
  localparam logic [6:0] OPC_ALUW  = 7'b0111011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_JMP   = 7'b1101111;
  localparam logic [6:0] OPC_JREG  = 7'b1100111;
  localparam logic [6:0] OPC_MEMO  = 7'b0001111;
  localparam logic [6:0] OPC_SYS   = 7'b1110011;

  localparam logic [6:0] F7_ZERO = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef struct packed {
    logic [6:0]  opc;
    logic [4:0]  rd;
    logic [2:0]  f3;
    logic [4:0]  rs1;
    logic [4:0]  rs2;
    logic [6:0]  f7;
    logic [11:0] imm;
  } fields_t;

endpackage

// File: rtl/alias_fields.sv
module alias_fields
  import alias_pkg::*;
(
  input  logic [ILEN-1:0] word,
  output fields_t         f
);
  always_comb begin
    f.opc = word[6:0];
    f.rd  = word[11:7];
    f.f3  = word[14:12];
    f.rs1 = word[19:15];
    f.rs2 = word[24:20];
    f.f7  = word[31:25];
    f.imm = word[31:20];
  end
endmodule

// File: rtl/alias_classify.sv
module alias_classify
  import alias_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  fields_t f,
  output alias_e  code,
  output logic    hit
);
  logic rd_z, rs1_z, rs2_z, imm_z, rd_ra, rs1_ra;
  logic [3:0] pred, succ;
  logic negw_ok;

  assign rd_z   = (f.rd  == 5'd0);
  assign rs1_z  = (f.rs1 == 5'd0);
  assign rs2_z  = (f.rs2 == 5'd0);
  assign imm_z  = (f.imm == 12'd0);
  assign rd_ra  = (f.rd  == 5'd1);
  assign rs1_ra = (f.rs1 == 5'd1);
  assign pred   = f.imm[7:4];
  assign succ   = f.imm[3:0];

  generate
    if (XLEN == 64) begin : g_wide
      assign negw_ok = (f.f7 == F7_ALT) && (f.f3 == 3'b000) && rs1_z;
    end else begin : g_narrow
      assign negw_ok = 1'b0;
    end
  endgenerate

  always_comb begin
    code = A_NONE;
    unique case (f.opc)
      OPC_ALUI: begin
        case (f.f3)
          3'b000: begin
            if (rd_z && rs1_z && imm_z) code = A_NOP;
            else if (imm_z)             code = A_MV;
          end
          3'b111: if (f.imm == 12'h0FF) code = A_ZEXTB;
          3'b100: if (f.imm == 12'hFFF) code = A_NOT;
          3'b011: if (f.imm == 12'h001) code = A_SEQZ;
          default: code = A_NONE;
        endcase
      end
      OPC_ALUR: begin
        if (f.f7 == F7_ALT && f.f3 == 3'b000 && rs1_z)       code = A_NEG;
        else if (f.f7 == F7_ZERO && f.f3 == 3'b011 && rs1_z) code = A_SNEZ;
      end
      OPC_ALUW: if (negw_ok) code = A_NEGW;
      OPC_BR: begin
        case (f.f3)
          3'b000: if (rs2_z) code = A_BEQZ;
          3'b001: if (rs2_z) code = A_BNEZ;
          3'b100: begin
            if (rs2_z)      code = A_BLTZ;
            else if (rs1_z) code = A_BGTZ;
          end
          3'b101: begin
            if (rs1_z)      code = A_BLEZ;
            else if (rs2_z) code = A_BGEZ;
          end
          default: code = A_NONE;
        endcase
      end
      OPC_JMP: begin
        if (rd_z)       code = A_J;
        else if (rd_ra) code = A_JALRA;
      end
      OPC_JREG: begin
        if (f.f3 == 3'b000 && rd_z) begin
          if (rs1_ra && imm_z) code = A_RET;
          else                 code = A_JR;
        end
      end
      OPC_MEMO: begin
        if (f.f3 == 3'b000) begin
          if (pred == 4'b0001 && succ == 4'b0000 && rd_z && rs1_z) code = A_PAUSE;
          else if (pred == 4'b1111 && succ == 4'b1111)             code = A_FENCE;
        end
      end
      OPC_SYS: begin
        if (f.f3 == 3'b010 && rs1_z) code = A_CSRR;
        else if (rd_z) begin
          case (f.f3)
            3'b001: code = A_CSRW;
            3'b010: code = A_CSRS;
            3'b011: code = A_CSRC;
            3'b101: code = A_CSRWI;
            3'b110: code = A_CSRSI;
            3'b111: code = A_CSRCI;
            default: code = A_NONE;
          endcase
        end
      end
      default: code = A_NONE;
    endcase
  end

  assign hit = (code != A_NONE);
endmodule

// File: rtl/alias_classifier.sv
module alias_classifier
  import alias_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       in_word,
  output logic              res_valid,
  output logic              res_hit,
  output logic [4:0]        res_code
);
  fields_t fld;
  alias_e  code_c;
  logic    hit_c;
  alias_e  code_q;

  alias_fields u_fields (
    .word (in_word),
    .f    (fld)
  );

  alias_classify #(.XLEN(XLEN)) u_classify (
    .f    (fld),
    .code (code_c),
    .hit  (hit_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      code_q    <= A_NONE;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_hit <= hit_c;
        code_q  <= code_c;
      end
    end
  end

  assign res_code = code_q;
endmodule

// File: rtl/alias_classifier_chk.sv
module alias_classifier_chk
  import alias_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        res_valid,
  input logic        res_hit,
  input logic [4:0]  res_code
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  p_valid_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(res_code) && $stable(res_hit)));

  p_hit_agrees_r3: assert property (@(posedge clk) disable iff (rst)
    res_hit == (res_code != 5'd0));

  p_nop_word_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == 32'h0000_0013) |=> (res_code == A_NOP));

  p_ret_word_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word == 32'h0000_8067) |=> (res_code == A_RET));

  p_branch_family_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_word[6:0] == OPC_BR) |=>
      (res_code == A_NONE || (res_code >= A_BEQZ && res_code <= A_BGEZ)));
endmodule

bind alias_classifier alias_classifier_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_word   (in_word),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_code  (res_code)
);

// File: tb/tb_alias_classifier.sv
module tb_alias_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_word = 32'h0;
  logic        res_valid, res_hit, n_valid, n_hit;
  logic [4:0]  res_code, n_code;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_classifier #(.XLEN(64)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .res_valid(res_valid), .res_hit(res_hit), .res_code(res_code));

  alias_classifier #(.XLEN(32)) dut_rv32 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
    .res_valid(n_valid), .res_hit(n_hit), .res_code(n_code));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] iw(input logic [11:0] imm, input logic [4:0] rs1,
                                     input logic [2:0] f3, input logic [4:0] rd,
                                     input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [31:0] rw(input logic [6:0] f7, input logic [4:0] rs2,
                                     input logic [4:0] rs1, input logic [2:0] f3,
                                     input logic [4:0] rd, input logic [6:0] opc);
    return {f7, rs2, rs1, f3, rd, opc};
  endfunction

  // Reference model written from the requirements
  function automatic int ref_code(input logic [31:0] w, input bit wide);
    logic [6:0] op = w[6:0];
    logic [4:0] rd = w[11:7], a = w[19:15], b = w[24:20];
    logic [2:0] f3 = w[14:12];
    logic [6:0] f7 = w[31:25];
    logic [11:0] im = w[31:20];
    if (op == 7'b0010011) begin
      if (f3 == 3'd0 && im == 0 && rd == 0 && a == 0) return 1;
      if (f3 == 3'd0 && im == 0) return 2;
      if (f3 == 3'd7 && im == 12'h0FF) return 3;
      if (f3 == 3'd4 && im == 12'hFFF) return 4;
      if (f3 == 3'd3 && im == 12'h001) return 5;
      return 0;
    end
    if (op == 7'b0110011) begin
      if (a == 0 && f3 == 0 && f7 == 7'h20) return 7;
      if (a == 0 && f3 == 3 && f7 == 7'h00) return 6;
      return 0;
    end
    if (op == 7'b0111011)
      return (wide && a == 0 && f3 == 0 && f7 == 7'h20) ? 8 : 0;
    if (op == 7'b1100011) begin
      if (f3 == 0) return (b == 0) ? 9 : 0;
      if (f3 == 1) return (b == 0) ? 10 : 0;
      if (f3 == 4) return (b == 0) ? 11 : ((a == 0) ? 12 : 0);
      if (f3 == 5) return (a == 0) ? 13 : ((b == 0) ? 14 : 0);
      return 0;
    end
    if (op == 7'b1101111) return (rd == 0) ? 15 : ((rd == 1) ? 16 : 0);
    if (op == 7'b1100111) begin
      if (f3 != 0 || rd != 0) return 0;
      return (a == 1 && im == 0) ? 18 : 17;
    end
    if (op == 7'b0001111) begin
      if (f3 != 0) return 0;
      if (w[27:20] == 8'h10 && rd == 0 && a == 0) return 19;
      if (w[27:20] == 8'hFF) return 20;
      return 0;
    end
    if (op == 7'b1110011) begin
      if (f3 == 2 && a == 0) return 21;
      if (rd != 0) return 0;
      case (f3)
        3'd1: return 22;
        3'd2: return 23;
        3'd3: return 24;
        3'd5: return 25;
        3'd6: return 26;
        3'd7: return 27;
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  function automatic logic [4:0] pick_reg();
    int s = int'($urandom % 4);
    if (s == 0) return 5'd0;
    if (s == 1) return 5'd1;
    return 5'($urandom);
  endfunction

  function automatic logic [31:0] rand_word();
    logic [6:0] opcs [9] = '{7'b0010011, 7'b0110011, 7'b0111011, 7'b1100011,
                             7'b1101111, 7'b1100111, 7'b0001111, 7'b1110011,
                             7'b0000011};
    logic [11:0] imm;
    logic [6:0]  f7;
    logic [31:0] w;
    int s = int'($urandom % 6);
    case (s)
      0: imm = 12'h000;
      1: imm = 12'h001;
      2: imm = 12'h0FF;
      3: imm = 12'hFFF;
      default: imm = 12'($urandom);
    endcase
    w = iw(imm, pick_reg(), 3'($urandom), pick_reg(), opcs[$urandom % 9]);
    s = int'($urandom % 3);
    f7 = (s == 0) ? 7'h00 : ((s == 1) ? 7'h20 : 7'($urandom));
    if (w[6:0] inside {7'b0110011, 7'b0111011, 7'b1100011}) begin
      w[31:25] = f7;
      w[24:20] = pick_reg();
    end
    if (w[6:0] == 7'b0001111) begin
      s = int'($urandom % 3);
      if (s == 0) w[27:20] = 8'h10;
      else if (s == 1) w[27:20] = 8'hFF;
    end
    return w;
  endfunction

  // Present one word, then sample both results at the following falling edge
  task automatic send(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_word  = w;
    @(negedge clk);
    in_valid = 1'b0;
    in_word  = ~w;
  endtask

  task automatic expect_code(input string req, input logic [31:0] w, input int exp);
    send(w);
    chk(req, int'(res_code), exp);
    chk({req, " hit"}, int'(res_hit), int'(exp != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset valid", int'(res_valid), 0);
    chk("R2 reset hit", int'(res_hit), 0);
    chk("R2 reset code", int'(res_code), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 timing: valid only the cycle after the strobe
    send(32'h0000_0013);
    chk("R1 valid after strobe", int'(res_valid), 1);
    @(negedge clk);
    chk("R1 valid idle", int'(res_valid), 0);
    // R2 hold while idle with changing input
    held = res_code;
    in_word = 32'h0000_8067;
    repeat (2) @(negedge clk);
    chk("R2 hold code", int'(res_code), int'(held));

    expect_code("R4 nop", iw(12'h0, 5'd0, 3'd0, 5'd0, 7'b0010011), 1);
    expect_code("R4 mv", iw(12'h0, 5'd3, 3'd0, 5'd5, 7'b0010011), 2);
    expect_code("R4 mv rd0 rs1nz", iw(12'h0, 5'd4, 3'd0, 5'd0, 7'b0010011), 2);
    expect_code("R4 addi nonzero imm", iw(12'h5, 5'd0, 3'd0, 5'd0, 7'b0010011), 0);
    expect_code("R5 zext.b", iw(12'h0FF, 5'd7, 3'd7, 5'd2, 7'b0010011), 3);
    expect_code("R5 not", iw(12'hFFF, 5'd7, 3'd4, 5'd2, 7'b0010011), 4);
    expect_code("R5 seqz", iw(12'h001, 5'd7, 3'd3, 5'd2, 7'b0010011), 5);
    expect_code("R5 andi 0x7F", iw(12'h07F, 5'd7, 3'd7, 5'd2, 7'b0010011), 0);
    expect_code("R6 neg", rw(7'h20, 5'd9, 5'd0, 3'd0, 5'd2, 7'b0110011), 7);
    expect_code("R6 snez", rw(7'h00, 5'd9, 5'd0, 3'd3, 5'd2, 7'b0110011), 6);
    expect_code("R6 add rs1 0", rw(7'h00, 5'd9, 5'd0, 3'd0, 5'd2, 7'b0110011), 0);
    expect_code("R6 negw wide", rw(7'h20, 5'd9, 5'd0, 3'd0, 5'd2, 7'b0111011), 8);
    chk("R6 negw narrow", int'(n_code), 0);
    chk("R6 negw narrow hit", int'(n_hit), 0);
    expect_code("R7 beqz", rw(7'h0, 5'd0, 5'd3, 3'd0, 5'd0, 7'b1100011), 9);
    expect_code("R7 bnez", rw(7'h0, 5'd0, 5'd3, 3'd1, 5'd0, 7'b1100011), 10);
    expect_code("R7 bltz both zero", rw(7'h0, 5'd0, 5'd0, 3'd4, 5'd0, 7'b1100011), 11);
    expect_code("R7 bgtz", rw(7'h0, 5'd6, 5'd0, 3'd4, 5'd0, 7'b1100011), 12);
    expect_code("R7 blez both zero", rw(7'h0, 5'd0, 5'd0, 3'd5, 5'd0, 7'b1100011), 13);
    expect_code("R7 bgez", rw(7'h0, 5'd0, 5'd6, 3'd5, 5'd0, 7'b1100011), 14);
    expect_code("R7 bltu no alias", rw(7'h0, 5'd0, 5'd6, 3'd6, 5'd0, 7'b1100011), 0);
    expect_code("R8 j", 32'h0100_006F, 15);
    expect_code("R8 jal ra", 32'h0100_00EF, 16);
    expect_code("R8 jal rd2", 32'h0100_016F, 0);
    expect_code("R8 ret", 32'h0000_8067, 18);
    expect_code("R8 jr offset", iw(12'h4, 5'd1, 3'd0, 5'd0, 7'b1100111), 17);
    expect_code("R8 jalr rd1", iw(12'h0, 5'd1, 3'd0, 5'd1, 7'b1100111), 0);
    expect_code("R9 pause", 32'h0100_000F, 19);
    expect_code("R9 pause rd nz", 32'h0100_008F, 0);
    expect_code("R9 fence full", 32'h0FF0_000F, 20);
    expect_code("R10 csrr", iw(12'h300, 5'd0, 3'd2, 5'd0, 7'b1110011), 21);
    expect_code("R10 csrw", iw(12'h300, 5'd4, 3'd1, 5'd0, 7'b1110011), 22);
    expect_code("R10 csrs", iw(12'h300, 5'd4, 3'd2, 5'd0, 7'b1110011), 23);
    expect_code("R10 csrc", iw(12'h300, 5'd4, 3'd3, 5'd0, 7'b1110011), 24);
    expect_code("R10 csrwi", iw(12'h300, 5'd4, 3'd5, 5'd0, 7'b1110011), 25);
    expect_code("R10 csrsi", iw(12'h300, 5'd4, 3'd6, 5'd0, 7'b1110011), 26);
    expect_code("R10 csrci", iw(12'h300, 5'd4, 3'd7, 5'd0, 7'b1110011), 27);
    expect_code("R10 csrrw rd nz", iw(12'h300, 5'd4, 3'd1, 5'd2, 7'b1110011), 0);
    expect_code("R3 load opcode", iw(12'h0, 5'd0, 3'd2, 5'd0, 7'b0000011), 0);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] w = rand_word();
      send(w);
      chk($sformatf("R3 random word %h", w), int'(res_code), ref_code(w, 1'b1));
      chk($sformatf("R3 random hit %h", w), int'(res_hit), int'(ref_code(w, 1'b1) != 0));
      chk($sformatf("R6 random narrow %h", w), int'(n_code), ref_code(w, 1'b0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule